// File: doc/BRIEF.md
# Dual-Slope Center-Aligned PWM Timer

This block is a 16-bit counter that ramps from zero up to a programmable ceiling and straight back down, over and over. Two output channels compare the count against their own thresholds to make symmetric, center-aligned pulse trains, which suits motor bridges where switching edges should stay balanced around the middle of each period. Each channel can be off, follow the threshold directly, or follow its complement.

Software sees four write-only registers through a small write port. Threshold and ceiling writes go into shadow copies and move into the live copies at one chosen point of the ramp: the floor (so every period is symmetric and its length never changes mid-period) or the peak (so the new threshold applies one half-period sooner). While the timer is disabled the live copies follow the shadows every cycle, so a stopped timer can be programmed without waiting for a ramp. The ceiling comes either from a dedicated period register or from channel A's threshold. A clock divider sets how many clocks make up one count step, and two strobes mark the moments the counter reaches its peak and its floor.

Top module: `dpwm_timer`

## Requirements
- R1: After reset both PWM outputs and both strobes are low, the control register is zero (both channels off, divider 1, ceiling from the period register, load at floor), both thresholds are 0 and the period register is 0xFFFF; enabled in that state, the first peak strobe arrives 65535 clocks after enable.
- R2: The counter steps by one per count tick from 0 up to the ceiling T, then down to 0, reversing at both ends with no extra dwell, so floor strobes are 2·T·N clocks apart with exactly one peak strobe between them.
- R3: The peak strobe and the floor strobe each stay high for a single clock, and never together.
- R4: With channel mode 2 (direct) and a threshold C with 0 < C < T, the output is high for 2·C count ticks out of every period: on the way up it is high while count < C, on the way down while count <= C.
- R5: With channel mode 3 (complement) the output is the inverse of the mode-2 level, high for 2·(T−C) ticks per period.
- R6: In mode 2 a threshold of 0 keeps the output low and a threshold of T or above keeps it high at all times; in mode 3 these levels swap.
- R7: Channel mode codes 0 and 1 drive the channel's output low.
- R8: Control bit 4 selects the ceiling: 0 takes the period register (address 1), 1 takes channel A's threshold (address 2).
- R9: A ceiling value below 3 is raised to 3.
- R10: Control bits [8:6] select the divider N: code 0 → 1, 1 → 8, 2 → 64, 3 → 256, 4 and above → 1024.
- R11: With control bit 5 clear, shadow thresholds and ceiling move to the live copies on the tick that brings the counter to 0.
- R12: With control bit 5 set, they move to the live copies on the tick that brings the counter up to the ceiling.
- R13: While enable is low the counter and its direction hold, the divider restarts from zero, no strobe fires, and the live copies follow the shadow registers every clock; counting resumes from the held value once enable returns.
- R14: A write with the write strobe high lands at the next clock edge: address 0 control (bits [1:0] channel A mode, [3:2] channel B mode), address 1 period, address 2 channel A threshold, address 3 channel B threshold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Count enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | 16 | Register write data |
| pwm_a | output | 1 | Channel A waveform |
| pwm_b | output | 1 | Channel B waveform |
| top_stb | output | 1 | One-clock pulse when the counter reaches the ceiling |
| bot_stb | output | 1 | One-clock pulse when the counter reaches zero |

## Verification
The bench builds the timer with its default parameters: a 16-bit counter and a 10-bit divider. At these widths the reset ceiling of 0xFFFF is reached in 65535 clocks, and the largest divider of 1024 fits in a few thousand clocks when the ceiling is set to its minimum of 3. That brings the reset ceiling, all five divider codes, the minimum-ceiling clamp and both load points within the cycle budget. Duty is measured as a count of high clocks over a whole period, so it does not depend on which phase the bench starts sampling in. The two load points are told apart by counting high clocks on the falling half of the ramp straight after a threshold is rewritten.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;

  typedef enum logic [1:0] {
    OUT_OFF     = 2'd0,
    OUT_OFF_ALT = 2'd1,
    OUT_DIRECT  = 2'd2,
    OUT_COMPL   = 2'd3
  } out_mode_e;

  typedef enum logic [1:0] {
    RA_CTRL   = 2'd0,
    RA_PERIOD = 2'd1,
    RA_CMP_A  = 2'd2,
    RA_CMP_B  = 2'd3
  } reg_addr_e;

  // Field order is the control register bit order, MSB first.
  typedef struct packed {
    logic [2:0] clk_sel;     // [8:6]
    logic       load_at_top; // [5]
    logic       top_from_a;  // [4]
    out_mode_e  mode_b;      // [3:2]
    out_mode_e  mode_a;      // [1:0]
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
  localparam int ADDR_W = 2;
  localparam int NUM_CH = 2;

  // log2 of the divide ratio for each clock-select code
  function automatic int unsigned psc_shift(input logic [2:0] sel);
    case (sel)
      3'd0:    return 0;
      3'd1:    return 3;
      3'd2:    return 6;
      3'd3:    return 8;
      default: return 10;
    endcase
  endfunction

endpackage

// File: rtl/dpwm_prescaler.sv
module dpwm_prescaler
  import dpwm_pkg::*;
#(
  parameter int PSC_W = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [2:0] clk_sel,
  output logic       tick
);

  logic [PSC_W-1:0] psc_q;
  logic [PSC_W-1:0] mask;
  int unsigned      shift;

  always_comb begin
    shift = psc_shift(clk_sel);
    for (int i = 0; i < PSC_W; i++) begin
      mask[i] = (i < int'(shift));
    end
  end

  // A tick fires when every divider bit below the chosen ratio is one.
  assign tick = en && ((psc_q & mask) == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psc_q <= '0;
    end else if (!en) begin
      psc_q <= '0;
    end else begin
      psc_q <= psc_q + 1'b1;
    end
  end

endmodule

// File: rtl/dpwm_regs.sv
module dpwm_regs
  import dpwm_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int TOP_MIN = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              load_evt,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  output ctrl_t             ctrl,
  output logic [CNT_W-1:0]  top_act,
  output logic [CNT_W-1:0]  cmp_a_act,
  output logic [CNT_W-1:0]  cmp_b_act
);

  localparam logic [CNT_W-1:0] TOP_FLOOR = CNT_W'(TOP_MIN);

  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] period_q;
  logic [CNT_W-1:0] cmp_a_q;
  logic [CNT_W-1:0] cmp_b_q;
  logic [CNT_W-1:0] top_src;
  logic [CNT_W-1:0] top_next;
  logic             take_shadow;

  assign ctrl        = ctrl_q;
  assign top_src     = ctrl_q.top_from_a ? cmp_a_q : period_q;
  assign top_next    = (top_src < TOP_FLOOR) ? TOP_FLOOR : top_src;
  assign take_shadow = !en || load_evt;

  // shadow registers: written straight from the port
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      period_q <= '1;
      cmp_a_q  <= '0;
      cmp_b_q  <= '0;
    end else if (wr_en) begin
      case (reg_addr_e'(wr_addr))
        RA_CTRL:   ctrl_q   <= ctrl_t'(wr_data[CTRL_W-1:0]);
        RA_PERIOD: period_q <= wr_data;
        RA_CMP_A:  cmp_a_q  <= wr_data;
        RA_CMP_B:  cmp_b_q  <= wr_data;
        default:   ;
      endcase
    end
  end

  // live registers: copied at the load point, or every clock when stopped
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      top_act   <= '1;
      cmp_a_act <= '0;
      cmp_b_act <= '0;
    end else if (take_shadow) begin
      top_act   <= top_next;
      cmp_a_act <= cmp_a_q;
      cmp_b_act <= cmp_b_q;
    end
  end

endmodule

// File: rtl/dpwm_counter.sv
module dpwm_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load_at_top,
  input  logic [CNT_W-1:0] top,
  output logic [CNT_W-1:0] cnt,
  output logic             down,
  output logic             hit_top,
  output logic             hit_bot,
  output logic             load_evt,
  output logic             top_stb,
  output logic             bot_stb
);

  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             down_q, down_n;

  // down_q marks that the present value was reached by a decrement
  always_comb begin
    cnt_n  = cnt_q;
    down_n = down_q;
    if (tick) begin
      if (!down_q) begin
        if (cnt_q >= top) begin
          cnt_n  = cnt_q - 1'b1;
          down_n = 1'b1;
        end else begin
          cnt_n = cnt_q + 1'b1;
        end
      end else begin
        if (cnt_q == '0) begin
          cnt_n  = cnt_q + 1'b1;
          down_n = 1'b0;
        end else begin
          cnt_n = cnt_q - 1'b1;
        end
      end
    end
  end

  assign hit_top  = tick && !down_n && (cnt_n == top);
  assign hit_bot  = tick && (cnt_n == '0);
  assign load_evt = load_at_top ? hit_top : hit_bot;
  assign cnt      = cnt_q;
  assign down     = down_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      down_q  <= 1'b0;
      top_stb <= 1'b0;
      bot_stb <= 1'b0;
    end else begin
      cnt_q   <= cnt_n;
      down_q  <= down_n;
      top_stb <= hit_top;
      bot_stb <= hit_bot;
    end
  end

endmodule

// File: rtl/dpwm_channel.sv
module dpwm_channel
  import dpwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  out_mode_e        mode,
  input  logic [CNT_W-1:0] cnt,
  input  logic             down,
  input  logic [CNT_W-1:0] cmp,
  input  logic [CNT_W-1:0] top,
  output logic             pwm
);

  // Direct-mode level: low at threshold 0, high at or above the ceiling,
  // otherwise cleared on the rising match and set on the falling match.
  function automatic logic direct_level(
    input logic [CNT_W-1:0] c,
    input logic             dn,
    input logic [CNT_W-1:0] th,
    input logic [CNT_W-1:0] tp
  );
    if (th == '0)      return 1'b0;
    else if (th >= tp) return 1'b1;
    else if (dn)       return (c <= th);
    else               return (c < th);
  endfunction

  logic level;

  assign level = direct_level(cnt, down, cmp, top);

  always_comb begin
    case (mode)
      OUT_DIRECT: pwm = level;
      OUT_COMPL:  pwm = !level;
      default:    pwm = 1'b0;
    endcase
  end

endmodule

// File: rtl/dpwm_timer.sv
module dpwm_timer
  import dpwm_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int PSC_W   = 10,
  parameter int TOP_MIN = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  output logic              pwm_a,
  output logic              pwm_b,
  output logic              top_stb,
  output logic              bot_stb
);

  ctrl_t            ctrl;
  logic             tick;
  logic             hit_top;
  logic             hit_bot;
  logic             load_evt;
  logic             down;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] top_act;
  logic [CNT_W-1:0] cmp_a_act;
  logic [CNT_W-1:0] cmp_b_act;

  logic [NUM_CH-1:0][CNT_W-1:0] ch_cmp;
  out_mode_e                    ch_mode [NUM_CH];
  logic [NUM_CH-1:0]            ch_pwm;

  dpwm_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .clk_sel (ctrl.clk_sel),
    .tick    (tick)
  );

  dpwm_regs #(.CNT_W(CNT_W), .TOP_MIN(TOP_MIN)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .load_evt  (load_evt),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .ctrl      (ctrl),
    .top_act   (top_act),
    .cmp_a_act (cmp_a_act),
    .cmp_b_act (cmp_b_act)
  );

  dpwm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .load_at_top (ctrl.load_at_top),
    .top         (top_act),
    .cnt         (cnt),
    .down        (down),
    .hit_top     (hit_top),
    .hit_bot     (hit_bot),
    .load_evt    (load_evt),
    .top_stb     (top_stb),
    .bot_stb     (bot_stb)
  );

  assign ch_cmp[0]  = cmp_a_act;
  assign ch_cmp[1]  = cmp_b_act;
  assign ch_mode[0] = ctrl.mode_a;
  assign ch_mode[1] = ctrl.mode_b;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    dpwm_channel #(.CNT_W(CNT_W)) u_ch (
      .mode (ch_mode[g]),
      .cnt  (cnt),
      .down (down),
      .cmp  (ch_cmp[g]),
      .top  (top_act),
      .pwm  (ch_pwm[g])
    );
  end

  assign pwm_a = ch_pwm[0];
  assign pwm_b = ch_pwm[1];

endmodule

// File: rtl/dpwm_timer_sva.sv
module dpwm_timer_sva #(
  parameter int CNT_W   = 16,
  parameter int TOP_MIN = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             tick,
  input logic [CNT_W-1:0] cnt,
  input logic             down,
  input logic [CNT_W-1:0] top_act,
  input logic [CNT_W-1:0] cmp_b_act,
  input logic [1:0]       mode_a,
  input logic [1:0]       mode_b,
  input logic             pwm_a,
  input logic             pwm_b,
  input logic             top_stb,
  input logic             bot_stb
);

  a_r2_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> ((cnt == $past(cnt) + 1'b1) || (cnt == $past(cnt) - 1'b1)));

  a_r3_top_single: assert property (@(posedge clk) disable iff (!rst_n)
    top_stb |=> !top_stb);

  a_r3_bot_single: assert property (@(posedge clk) disable iff (!rst_n)
    bot_stb |=> !bot_stb);

  a_r3_not_both: assert property (@(posedge clk) disable iff (!rst_n)
    !(top_stb && bot_stb));

  a_r6_zero_low: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_b == 2'd2 && cmp_b_act == '0) |-> !pwm_b);

  a_r6_ceiling_high: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_b == 2'd2 && cmp_b_act >= top_act) |-> pwm_b);

  a_r7_off_a_low: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_a[1] |-> !pwm_a);

  a_r7_off_b_low: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_b[1] |-> !pwm_b);

  a_r9_top_floor: assert property (@(posedge clk) disable iff (!rst_n)
    top_act >= CNT_W'(TOP_MIN));

  a_r13_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt == $past(cnt)) && (down == $past(down)) && !top_stb && !bot_stb);

endmodule

bind dpwm_timer dpwm_timer_sva #(.CNT_W(CNT_W), .TOP_MIN(TOP_MIN)) u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .en        (en),
  .tick      (tick),
  .cnt       (cnt),
  .down      (down),
  .top_act   (top_act),
  .cmp_b_act (cmp_b_act),
  .mode_a    (ctrl.mode_a),
  .mode_b    (ctrl.mode_b),
  .pwm_a     (pwm_a),
  .pwm_b     (pwm_b),
  .top_stb   (top_stb),
  .bot_stb   (bot_stb)
);

// File: tb/dpwm_timer_tb.sv
`timescale 1ns/1ps
module dpwm_timer_tb;

  localparam int WAIT_MAX = 70000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        pwm_a, pwm_b, top_stb, bot_stb;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  dpwm_timer u_dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .pwm_a   (pwm_a),
    .pwm_b   (pwm_b),
    .top_stb (top_stb),
    .bot_stb (bot_stb)
  );

  // {channel B mode, ceiling, threshold, expected high clocks per period}
  localparam int NVEC = 13;
  localparam int VEC [NVEC][4] = '{
    '{2, 10,  4,  8}, '{2, 10,  7, 14}, '{3, 10,  4, 12}, '{3, 10,  1, 18},
    '{2, 10,  0,  0}, '{2, 10, 10, 20}, '{2, 10, 15, 20}, '{3, 10,  0, 20},
    '{3, 10, 10,  0}, '{0, 10,  4,  0}, '{1, 10,  4,  0}, '{2,  3,  1,  2},
    '{2,  3,  2,  4}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] ctrl_word(input int ma, input int mb, input int tfa,
                                            input int lat, input int cs);
    return 16'((cs << 6) | (lat << 5) | (tfa << 4) | (mb << 2) | ma);
  endfunction

  task automatic wr(input int addr, input int data);
    wr_en   = 1'b1;
    wr_addr = 2'(addr);
    wr_data = 16'(data);
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic do_reset();
    en    = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic setup(input logic [15:0] ctrl, input int period, input int cmpa, input int cmpb);
    do_reset();
    wr(0, ctrl);
    wr(1, period);
    wr(2, cmpa);
    wr(3, cmpb);
    en = 1'b1;
  endtask

  task automatic wait_bot(output bit ok);
    int n = 0;
    while (!bot_stb && n < WAIT_MAX) begin
      @(negedge clk);
      n++;
    end
    ok = bot_stb;
  endtask

  // from a floor strobe, clocks until the next one and peak strobes seen
  task automatic measure(output int cyc, output int tops, output bit first_low);
    cyc  = 0;
    tops = 0;
    @(negedge clk);
    cyc++;
    first_low = !bot_stb;
    if (top_stb) tops++;
    while (!bot_stb && cyc < WAIT_MAX) begin
      @(negedge clk);
      cyc++;
      if (top_stb) tops++;
    end
  endtask

  initial begin
    #(5.0 * 180000);
    check(1'b0, "R2 watchdog", 0, 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit ok;
    int cyc, tops, hi, n;
    bit first_low;
    logic lvl;

    // R1 reset state
    do_reset();
    check(pwm_a == 1'b0 && pwm_b == 1'b0, "R1 outputs low", int'(pwm_a | pwm_b), 0);
    check(top_stb == 1'b0 && bot_stb == 1'b0, "R1 strobes low", int'(top_stb | bot_stb), 0);
    en = 1'b1;
    n = 0;
    while (!top_stb && n < WAIT_MAX) begin
      @(negedge clk);
      n++;
    end
    check(n == 65535, "R1 reset ceiling 0xFFFF", n, 65535);
    check(pwm_a == 1'b0 && pwm_b == 1'b0, "R7 reset modes off", int'(pwm_a | pwm_b), 0);

    // R4 R5 R6 R7 R14: duty table, written through the register port
    for (int i = 0; i < NVEC; i++) begin
      string tag;
      setup(ctrl_word(0, VEC[i][0], 0, 0, 0), VEC[i][1], 0, VEC[i][2]);
      wait_bot(ok);
      hi = 0;
      for (int k = 0; k < 2 * VEC[i][1]; k++) begin
        if (pwm_b) hi++;
        @(negedge clk);
      end
      if (VEC[i][0] < 2) tag = "R7 off";
      else if (VEC[i][2] == 0 || VEC[i][2] >= VEC[i][1]) tag = "R6 extreme";
      else if (VEC[i][0] == 2) tag = "R4 direct";
      else tag = "R5 complement";
      check(ok && hi == VEC[i][3], tag, hi, VEC[i][3]);
    end

    // R2 R3 R10: period per divider code with ceiling 3
    for (int cs = 0; cs < 8; cs++) begin
      int nd;
      if (cs == 5 || cs == 6) continue;
      nd = (cs == 0) ? 1 : (cs == 1) ? 8 : (cs == 2) ? 64 : (cs == 3) ? 256 : 1024;
      setup(ctrl_word(0, 0, 0, 0, cs), 3, 0, 0);
      wait_bot(ok);
      measure(cyc, tops, first_low);
      check(ok && cyc == 6 * nd, "R10 divider period", cyc, 6 * nd);
      check(tops == 1, "R2 one peak per period", tops, 1);
      check(first_low, "R3 floor strobe one clock", int'(!first_low), 0);
    end

    // R2 ceiling from period register; R8 ceiling from channel A
    setup(ctrl_word(2, 0, 0, 0, 0), 10, 5, 0);
    wait_bot(ok);
    measure(cyc, tops, first_low);
    check(ok && cyc == 20, "R2 period from period register", cyc, 20);
    setup(ctrl_word(2, 0, 1, 0, 0), 10, 5, 0);
    wait_bot(ok);
    measure(cyc, tops, first_low);
    check(ok && cyc == 10, "R8 period from channel A", cyc, 10);
    check(pwm_a == 1'b1, "R6 channel A at ceiling high", int'(pwm_a), 1);

    // R9 clamp
    setup(ctrl_word(0, 0, 0, 0, 0), 1, 0, 0);
    wait_bot(ok);
    measure(cyc, tops, first_low);
    check(ok && cyc == 6, "R9 ceiling 1 clamped", cyc, 6);
    setup(ctrl_word(0, 0, 0, 0, 0), 0, 0, 0);
    wait_bot(ok);
    measure(cyc, tops, first_low);
    check(ok && cyc == 6, "R9 ceiling 0 clamped", cyc, 6);

    // R11 R12: rewrite threshold after a floor, count the falling half
    for (int lat = 0; lat < 2; lat++) begin
      int exp_hi;
      setup(ctrl_word(0, 2, 0, lat, 0), 10, 0, 2);
      wait_bot(ok);
      wr(3, 8);
      n = 0;
      while (!top_stb && n < 100) begin
        @(negedge clk);
        n++;
      end
      hi = 0;
      while (!bot_stb && n < 200) begin
        if (pwm_b) hi++;
        @(negedge clk);
        n++;
      end
      exp_hi = lat ? 8 : 2;
      check(hi == exp_hi, lat ? "R12 load at peak" : "R11 load at floor", hi, exp_hi);
    end

    // R13 hold while disabled
    setup(ctrl_word(0, 2, 0, 0, 0), 10, 0, 4);
    wait_bot(ok);
    repeat (3) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    lvl = pwm_b;
    n = 0;
    for (int k = 0; k < 40; k++) begin
      if (top_stb || bot_stb || pwm_b != lvl) n++;
      @(negedge clk);
    end
    check(n == 0, "R13 frozen while disabled", n, 0);
    check(lvl == 1'b1, "R13 held level", int'(lvl), 1);
    wr(3, 0);
    @(negedge clk);
    check(pwm_b == 1'b0, "R13 live copy follows shadow", int'(pwm_b), 0);
    wr(3, 4);
    en = 1'b1;
    wait_bot(ok);
    measure(cyc, tops, first_low);
    check(ok && cyc == 20, "R13 resumes period", cyc, 20);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule